// File: doc/BRIEF.md
# Exponential Backoff Lockout Timer

This block enforces a waiting period after a run of failed authentication attempts. Logic around it keeps the number of consecutive failures and pulses `start` after each wrong attempt. The block then turns that count into a wait length in seconds. The wait is five seconds, doubled for each failure after the first. The exponent stops growing at ten failures and the result is held to at most 2560 seconds.

The wait is loaded into a 12-bit seconds counter. That counter steps down once per pulse of an external one-second `tick`. While it is non-zero, `locked` is held high. A `clear` pulse stands for a successful attempt: it drops any wait in progress and zeroes the attempt count held inside the block.

The tick source and the non-volatile copy of the attempt count are outside the block.

Top module: `backoff_timer`

## Requirements
- R1: For an attempt count a of one or more, a `start` pulse loads `remaining` on the next clock edge with 5 × 2^(min(a,10) − 1) seconds (for example a=6 gives 160 and a=9 gives 1280).
- R2: Counts of one to five failures give waits of 5, 10, 20, 40 and 80 seconds.
- R3: The loaded wait is never above 2560 seconds. Every count of ten or more (10, 11 and 255 included) gives exactly 2560.
- R4: A `start` with an attempt count of zero loads no wait: `remaining` becomes 0 and `locked` stays low.
- R5: `locked` rises on the clock edge that follows a `start` with a non-zero count, and it stays high while `remaining` is non-zero.
- R6: Each `tick` pulse lowers `remaining` by exactly one while it is non-zero. Without a tick, `remaining` holds its value.
- R7: `locked` falls on the tick that brings `remaining` to zero. Ticks arriving once `remaining` is zero leave `remaining` at 0 and `locked` low.
- R8: A `start` during a running wait reloads `remaining` from the value computed for the new count. It does not add to the old value.
- R9: `clear` zeroes `remaining`, `locked` and `held_attempts` on the next edge. When `clear` and `start` come in the same cycle, `clear` takes priority.
- R10: After reset, `remaining`, `locked` and `held_attempts` are all zero. A `start` copies `fail_count` into `held_attempts`.
- R11: When `start` and `tick` come in the same cycle, the load takes priority and no decrement is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that starts a wait for `fail_count` |
| clear | input | 1 | One-cycle pulse on a successful attempt; cancels the wait and zeroes the held count |
| tick | input | 1 | One-cycle pulse each second |
| fail_count | input | 8 | Consecutive failed attempts |
| locked | output | 1 | High while a wait is running |
| remaining | output | 12 | Seconds left in the current wait |
| held_attempts | output | 8 | Attempt count captured at the last start, zeroed by clear |

## Verification
The cases hardest to reach are the ones where two controls land in the same clock cycle. These are `start` together with `tick`, `clear` together with `start`, and a reload in the middle of a countdown. Normal use spaces these events seconds apart, so they would almost never line up on their own. The bench drives each control from one task on the falling edge, so any pair can be asserted in the same cycle on purpose. The short five-second wait is run to zero one tick at a time, which places the bench exactly on the tick that makes `locked` fall and on the ticks that follow it.

// File: rtl/backoff_pkg.sv
// Package: shared widths and the constants of the backoff law.
// Assumes: the defaults keep 5 << 9 inside REM_W bits.
package backoff_pkg;
    localparam int unsigned CNT_W     = 8;     // width of the attempt count
    localparam int unsigned REM_W     = 12;    // width of the seconds counter
    localparam int unsigned BASE_SEC  = 5;     // wait after the first failure
    localparam int unsigned EXP_LIMIT = 10;    // attempt count at which doubling stops
    localparam int unsigned CAP_SEC   = 2560;  // absolute ceiling on the wait

    // Control priority decided at the top level.
    typedef enum logic [1:0] {
        CTL_IDLE   = 2'd0,
        CTL_CANCEL = 2'd1,
        CTL_LOAD   = 2'd2,
        CTL_STEP   = 2'd3
    } ctl_e;
endpackage

// File: rtl/backoff_law.sv
// Module: backoff_law
// Purely combinational. Turns an attempt count into a wait in seconds:
// zero for no attempts, otherwise BASE doubled (min(a,LIMIT)-1) times,
// then held to CAP.
// Assumes: BASE << (LIMIT-1) fits in 32 bits.
module backoff_law #(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned REM_W     = 12,
    parameter int unsigned BASE_SEC  = 5,
    parameter int unsigned EXP_LIMIT = 10,
    parameter int unsigned CAP_SEC   = 2560
) (
    input  logic [CNT_W-1:0] attempts,
    output logic [REM_W-1:0] wait_sec
);
    localparam logic [31:0] LIMIT32 = 32'(EXP_LIMIT);
    localparam logic [31:0] CAP32   = 32'(CAP_SEC);
    localparam logic [31:0] BASE32  = 32'(BASE_SEC);

    logic [31:0] att32;
    logic [31:0] clamped;
    logic [31:0] raw;
    logic [31:0] capped;

    // Limit the exponent, shift the base and apply the ceiling.
    always_comb begin
        att32   = 32'(attempts);
        clamped = (att32 > LIMIT32) ? LIMIT32 : att32;
        if (clamped == 32'd0) begin
            raw = 32'd0;
        end else begin
            raw = BASE32 << (clamped - 32'd1);
        end
        capped   = (raw > CAP32) ? CAP32 : raw;
        wait_sec = capped[REM_W-1:0];
    end

    // The ceiling must survive the narrowing to REM_W bits.
    always_comb begin
        AST_LAW_CAP: assert (32'(wait_sec) <= CAP32); // R3
    end
endmodule

// File: rtl/backoff_counter.sv
// Module: backoff_counter
// Holds the seconds counter and the lock flag. Priority is
// cancel > load > step.
// Assumes: step is at most one pulse per clock, and load_val <= CAP_SEC.
module backoff_counter #(
    parameter int unsigned REM_W   = 12,
    parameter int unsigned CAP_SEC = 2560
) (
    input  logic             clk,
    input  logic             rst_n,
    input  backoff_pkg::ctl_e ctl,
    input  logic [REM_W-1:0] load_val,
    output logic [REM_W-1:0] remaining,
    output logic             locked
);
    import backoff_pkg::*;

    localparam logic [REM_W-1:0] ONE = REM_W'(1);

    logic [REM_W-1:0] rem_q;
    logic             lock_q;

    // Seconds counter: zeroed, reloaded or stepped down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else begin
            unique case (ctl)
                CTL_CANCEL: rem_q <= '0;
                CTL_LOAD:   rem_q <= load_val;
                CTL_STEP:   if (rem_q != '0) rem_q <= rem_q - ONE;
                default:    rem_q <= rem_q;
            endcase
        end
    end

    // Lock flag: set by a non-zero load, cleared by cancel or by the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else begin
            unique case (ctl)
                CTL_CANCEL: lock_q <= 1'b0;
                CTL_LOAD:   lock_q <= (load_val != '0);
                CTL_STEP:   if (rem_q == ONE) lock_q <= 1'b0;
                default:    lock_q <= lock_q;
            endcase
        end
    end

    assign remaining = rem_q;
    assign locked    = lock_q;

    AST_LOCK_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        locked == (remaining != '0)); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        32'(remaining) <= 32'(CAP_SEC)); // R3

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == CTL_STEP && remaining != '0) |=> remaining == $past(remaining) - ONE); // R6

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == CTL_IDLE) |=> $stable(remaining)); // R6

    AST_LAST_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == CTL_STEP && remaining == ONE) |=> !locked); // R7

    AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == CTL_CANCEL) |=> (remaining == '0 && !locked)); // R9
endmodule

// File: rtl/backoff_timer.sv
// Module: backoff_timer (top)
// Lockout timer for failed attempts. Captures the attempt count on start,
// works out the capped exponential wait and counts it down on one-second
// ticks. Arbitration: clear > start > tick.
// Assumes: start, clear and tick are one-cycle pulses synchronous to clk.
module backoff_timer #(
    parameter int unsigned CNT_W     = backoff_pkg::CNT_W,
    parameter int unsigned REM_W     = backoff_pkg::REM_W,
    parameter int unsigned BASE_SEC  = backoff_pkg::BASE_SEC,
    parameter int unsigned EXP_LIMIT = backoff_pkg::EXP_LIMIT,
    parameter int unsigned CAP_SEC   = backoff_pkg::CAP_SEC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] fail_count,
    output logic             locked,
    output logic [REM_W-1:0] remaining,
    output logic [CNT_W-1:0] held_attempts
);
    import backoff_pkg::*;

    ctl_e             ctl;
    logic [REM_W-1:0] wait_sec;
    logic [CNT_W-1:0] held_q;

    // Arbitrate the three controls into a single command.
    always_comb begin
        if (clear)      ctl = CTL_CANCEL;
        else if (start) ctl = CTL_LOAD;
        else if (tick)  ctl = CTL_STEP;
        else            ctl = CTL_IDLE;
    end

    // Keep the attempt count seen at the last start; clear zeroes it.
    always_ff @(posedge clk) begin
        if (!rst_n)      held_q <= '0;
        else if (clear)  held_q <= '0;
        else if (start)  held_q <= fail_count;
    end

    backoff_law #(
        .CNT_W(CNT_W), .REM_W(REM_W), .BASE_SEC(BASE_SEC),
        .EXP_LIMIT(EXP_LIMIT), .CAP_SEC(CAP_SEC)
    ) u_law (
        .attempts (fail_count),
        .wait_sec (wait_sec)
    );

    backoff_counter #(
        .REM_W(REM_W), .CAP_SEC(CAP_SEC)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .load_val  (wait_sec),
        .remaining (remaining),
        .locked    (locked)
    );

    assign held_attempts = held_q;

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !clear) |=> held_attempts == $past(fail_count)); // R10

    AST_ZERO_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !clear && fail_count == '0) |=> (!locked && remaining == '0)); // R4

    AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !clear && fail_count != '0) |=> locked); // R5

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (held_attempts == '0 && !locked)); // R9
endmodule

// File: tb/tb_backoff_timer.sv
module tb_backoff_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        clear = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  fail_count = 8'd0;
    logic        locked;
    logic [11:0] remaining;
    logic [7:0]  held_attempts;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    backoff_timer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .clear(clear), .tick(tick),
        .fail_count(fail_count), .locked(locked), .remaining(remaining),
        .held_attempts(held_attempts)
    );

    localparam int NV = 11;
    localparam int VEC_A [NV] = '{0, 1, 2, 3, 4, 5, 6, 9, 10, 11, 255};
    localparam int VEC_W [NV] = '{0, 5, 10, 20, 40, 80, 160, 1280, 2560, 2560, 2560};

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive one cycle of controls from a falling edge, then sample at the next falling edge.
    task automatic cyc(input bit s, input bit c, input bit t, input int a);
        start = s; clear = c; tick = t; fail_count = 8'(a);
        @(negedge clk);
        start = 1'b0; clear = 1'b0; tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 reset remaining", int'(remaining), 0);
        chk("R10 reset locked", int'(locked), 0);
        chk("R10 reset held", int'(held_attempts), 0);

        // Table walk: R1 R2 R3 R4 R5 R10
        for (int i = 0; i < NV; i++) begin
            cyc(0, 1, 0, 0);
            cyc(1, 0, 0, VEC_A[i]);
            chk($sformatf("R1/R2/R3/R4 wait a=%0d", VEC_A[i]), int'(remaining), VEC_W[i]);
            chk($sformatf("R4/R5 locked a=%0d", VEC_A[i]), int'(locked), (VEC_W[i] != 0) ? 1 : 0);
            chk($sformatf("R10 held a=%0d", VEC_A[i]), int'(held_attempts), VEC_A[i]);
        end

        // R6 R7: full countdown of the 5 s wait
        cyc(0, 1, 0, 0);
        cyc(1, 0, 0, 1);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        chk("R6 hold without tick", int'(remaining), 5);
        for (int k = 1; k <= 4; k++) begin
            cyc(0, 0, 1, 0);
            chk("R6 tick decrement", int'(remaining), 5 - k);
            chk("R5 locked during wait", int'(locked), 1);
        end
        cyc(0, 0, 1, 0);
        chk("R7 last tick remaining", int'(remaining), 0);
        chk("R7 last tick unlocks", int'(locked), 0);
        cyc(0, 0, 1, 0);
        cyc(0, 0, 1, 0);
        chk("R7 extra ticks remaining", int'(remaining), 0);
        chk("R7 extra ticks locked", int'(locked), 0);

        // R8: reload mid-wait
        cyc(1, 0, 0, 3);
        cyc(0, 0, 1, 0);
        cyc(0, 0, 1, 0);
        chk("R8 pre-reload", int'(remaining), 18);
        cyc(1, 0, 0, 2);
        chk("R8 reload value", int'(remaining), 10);
        chk("R8 held after reload", int'(held_attempts), 2);

        // R11: start and tick together
        cyc(1, 0, 1, 4);
        chk("R11 start beats tick", int'(remaining), 40);

        // R9: clear cancels
        cyc(0, 1, 0, 0);
        chk("R9 clear remaining", int'(remaining), 0);
        chk("R9 clear locked", int'(locked), 0);
        chk("R9 clear held", int'(held_attempts), 0);

        // R9: clear together with start
        cyc(1, 0, 0, 5);
        cyc(1, 1, 0, 7);
        chk("R9 clear beats start remaining", int'(remaining), 0);
        chk("R9 clear beats start locked", int'(locked), 0);
        chk("R9 clear beats start held", int'(held_attempts), 0);

        // R4: zero count over a running wait stops it
        cyc(1, 0, 0, 2);
        cyc(1, 0, 0, 0);
        chk("R4 zero count remaining", int'(remaining), 0);
        chk("R4 zero count locked", int'(locked), 0);

        // R10: reset mid-wait
        cyc(1, 0, 0, 6);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10 reset mid-wait remaining", int'(remaining), 0);
        chk("R10 reset mid-wait locked", int'(locked), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule